// File: doc/BRIEF.md
# Counting Barrier Synchronizer

This block holds a fixed group of participants at a meeting point until every one of them has arrived, then lets them all go together. It keeps one shared occupancy counter and two gate flags: an entry gate that admits arrivals one at a time, and an exit gate that admits departures one at a time. The counter climbs as participants check in and falls as they check out. Because the entry gate stays shut until the counter is back at zero, a fast participant cannot slip into the next round while slower ones are still leaving the current one.

Each participant drives a one-cycle `arrive` strobe to check in and a one-cycle `leave` strobe to check out. It watches its own `release` output. When several participants strobe in the same cycle, they are admitted one per cycle, lowest index first. A strobe that cannot be served at once is remembered, not lost. The group size is a parameter.

Top module: `barrier_sync`

## Requirements
- R1: After a synchronous reset the occupancy count is 0, the entry gate is open, the exit gate is closed and every release output is low.
- R2: The block admits pending arrivals one per cycle, lowest index first. When all N participants strobe arrive on the same clock edge E, every release goes high after edge E+N and is still low after edge E+N-1.
- R3: No release output goes high while fewer than N participants have been counted in.
- R4: The clock edge that counts the N-th arrival opens the exit gate and closes the entry gate. Every release output is high after the following edge, so a lone final arrival sampled at edge E produces release after edge E+1.
- R5: A participant's release output stays high until that participant strobes leave, and is low after the edge that samples the strobe.
- R6: A leave strobe from a participant whose release is low has no effect. This covers a participant that is idle, waiting to be counted, or counted but not yet released.
- R7: The block serves departures one per cycle, each lowering the count by one. The exit gate stays open until the count returns to 0. At that point the exit gate closes and the entry gate reopens.
- R8: An arrive strobe sampled while the entry gate is closed, including one sent while the same participant is still waiting to depart, is held pending. It is counted once the entry gate reopens.
- R9: A participant contributes at most one count per round: extra arrive strobes while it is already pending or counted are ignored. The count never exceeds N, and the two gates are never open together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| arrive_i | input | N_PART | Per-participant check-in strobe |
| leave_i | input | N_PART | Per-participant check-out strobe |
| release_o | output | N_PART | Per-participant go signal, high from barrier completion until that participant leaves |

## Verification
The properties assume that each participant follows the protocol: it strobes arrive only when it means to join the next round, and it strobes leave only after its release has been seen. They also assume that inputs change only away from the rising edge. The stimulus drives strobes for exactly one edge, each on a falling edge. Stray strobes (duplicate arrivals, early leaves, re-arrivals during departure) are sent on purpose to exercise the ignore and hold-pending rules, and they are never sent faster than one per participant per cycle.

// File: rtl/barsync_pkg.sv
package barsync_pkg;

    // Life cycle of one participant slot within a barrier round.
    typedef enum logic [2:0] {
        SL_IDLE        = 3'd0,  // outside the barrier
        SL_WAIT        = 3'd1,  // arrival requested, not yet counted
        SL_IN          = 3'd2,  // counted, held or released
        SL_LEAVE       = 3'd3,  // leave seen, waiting for exit gate
        SL_LEAVE_REARM = 3'd4   // leave seen and already asked to re-enter
    } slot_state_e;

    // The two shared gate flags.
    typedef struct packed {
        logic entry_open;
        logic exit_open;
    } gate_t;

    localparam gate_t GATE_RESET = '{entry_open: 1'b1, exit_open: 1'b0};

endpackage

// File: rtl/barsync_picker.sv
module barsync_picker #(
    parameter int W = 4
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] gnt_o,
    output logic         any_o
);
    // Fixed priority: lowest index wins.
    always_comb begin
        logic hit;
        hit   = 1'b0;
        gnt_o = '0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i] && !hit) begin
                gnt_o[i] = 1'b1;
                hit      = 1'b1;
            end
        end
        any_o = hit;
    end
endmodule

// File: rtl/barsync_slot.sv
module barsync_slot
    import barsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arrive_i,
    input  logic leave_i,
    input  logic exit_open_i,
    input  logic entry_gnt_i,
    input  logic exit_gnt_i,
    output logic want_entry_o,
    output logic want_exit_o,
    output logic release_o
);
    slot_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SL_IDLE:        if (arrive_i) st_d = SL_WAIT;
            SL_WAIT:        if (entry_gnt_i) st_d = SL_IN;
            SL_IN:          if (leave_i && exit_open_i) st_d = SL_LEAVE;
            SL_LEAVE: begin
                if (exit_gnt_i)    st_d = arrive_i ? SL_WAIT : SL_IDLE;
                else if (arrive_i) st_d = SL_LEAVE_REARM;
            end
            SL_LEAVE_REARM: if (exit_gnt_i) st_d = SL_WAIT;
            default:        st_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SL_IDLE;
        else     st_q <= st_d;
    end

    assign want_entry_o = (st_q == SL_WAIT);
    assign want_exit_o  = (st_q == SL_LEAVE) || (st_q == SL_LEAVE_REARM);
    assign release_o    = (st_q == SL_IN) && exit_open_i;
endmodule

// File: rtl/barsync_gates.sv
module barsync_gates
    import barsync_pkg::*;
#(
    parameter int N_PART = 4,
    parameter int CW     = $clog2(N_PART + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          entry_take_i,
    input  logic          exit_take_i,
    output logic [CW-1:0] count_o,
    output gate_t         gate_o
);
    localparam logic [CW-1:0] LAST_IN  = CW'(N_PART - 1);
    localparam logic [CW-1:0] LAST_OUT = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            gate_o  <= GATE_RESET;
        end else if (gate_o.entry_open && entry_take_i) begin
            count_o <= count_o + 1'b1;
            if (count_o == LAST_IN) begin
                gate_o.entry_open <= 1'b0;
                gate_o.exit_open  <= 1'b1;
            end
        end else if (gate_o.exit_open && exit_take_i) begin
            count_o <= count_o - 1'b1;
            if (count_o == LAST_OUT) begin
                gate_o.exit_open  <= 1'b0;
                gate_o.entry_open <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barsync_pkg::*;
#(
    parameter int N_PART = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PART-1:0] arrive_i,
    input  logic [N_PART-1:0] leave_i,
    output logic [N_PART-1:0] release_o
);
    localparam int CW = $clog2(N_PART + 1);

    logic [N_PART-1:0] want_entry, want_exit;
    logic [N_PART-1:0] entry_req, exit_req;
    logic [N_PART-1:0] entry_gnt, exit_gnt;
    logic              entry_any, exit_any;
    logic [CW-1:0]     count_q;
    gate_t             gate_q;
    logic              entry_open, exit_open;

    assign entry_open = gate_q.entry_open;
    assign exit_open  = gate_q.exit_open;
    assign entry_req  = want_entry & {N_PART{entry_open}};
    assign exit_req   = want_exit  & {N_PART{exit_open}};

    barsync_picker #(.W(N_PART)) u_entry_pick (
        .req_i(entry_req), .gnt_o(entry_gnt), .any_o(entry_any)
    );
    barsync_picker #(.W(N_PART)) u_exit_pick (
        .req_i(exit_req), .gnt_o(exit_gnt), .any_o(exit_any)
    );

    barsync_gates #(.N_PART(N_PART), .CW(CW)) u_gates (
        .clk(clk), .rst(rst),
        .entry_take_i(entry_any), .exit_take_i(exit_any),
        .count_o(count_q), .gate_o(gate_q)
    );

    for (genvar g = 0; g < N_PART; g++) begin : g_slot
        barsync_slot u_slot (
            .clk(clk), .rst(rst),
            .arrive_i(arrive_i[g]), .leave_i(leave_i[g]),
            .exit_open_i(exit_open),
            .entry_gnt_i(entry_gnt[g]), .exit_gnt_i(exit_gnt[g]),
            .want_entry_o(want_entry[g]), .want_exit_o(want_exit[g]),
            .release_o(release_o[g])
        );
    end
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter int N_PART = 4,
    parameter int CW     = $clog2(N_PART + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PART-1:0] leave_i,
    input logic [N_PART-1:0] release_o,
    input logic [CW-1:0]     count_q,
    input logic              entry_open,
    input logic              exit_open
);
    // R1: reset state of the counter and gates
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count_q == '0 && entry_open && !exit_open));

    // R9: gates are mutually exclusive and the count is bounded
    assert_gates_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(entry_open && exit_open));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(N_PART));

    // R2 / R7: count moves by at most one per cycle
    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1
                  || count_q == $past(count_q) - 1'b1));

    // R3: release only once the exit gate has opened
    assert_no_early_release_R3: assert property (@(posedge clk) disable iff (rst)
        (release_o != '0) |-> exit_open);

    // R4: a full count means the exit gate is open
    assert_full_opens_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (count_q == CW'(N_PART)) |-> exit_open);

    // R7: an empty barrier has its entry gate open
    assert_empty_reopens_R7: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> entry_open);

    // R5: a release only drops after that participant's leave strobe
    for (genvar g = 0; g < N_PART; g++) begin : g_rel
        assert_release_hold_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(release_o[g]) |-> $past(leave_i[g]));
    end
endmodule

bind barrier_sync barrier_sync_chk #(.N_PART(N_PART)) u_chk (
    .clk(clk), .rst(rst), .leave_i(leave_i), .release_o(release_o),
    .count_q(count_q), .entry_open(entry_open), .exit_open(exit_open)
);

// File: tb/barrier_sync_test.sv
`timescale 1ns/1ps
module barrier_sync_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] leave  = '0;
    logic [N-1:0] release_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int           at;
        logic [N-1:0] val;
        string        tag;
    } exp_t;
    exp_t sb[$];

    barrier_sync #(.N_PART(N)) uut (
        .clk(clk), .rst(rst), .arrive_i(arrive), .leave_i(leave), .release_o(release_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input logic [N-1:0] exp, input string tag);
        checks++;
        if (release_o !== exp) begin
            errors++;
            $display("FAIL %s: release=%b expected %b (cycle %0d)", tag, release_o, exp, cyc);
        end
    endtask

    // Monitor: pops expectations whose cycle has come.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            if (it.at < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s: release=missed expected %b (cycle %0d)", it.tag, it.val, it.at);
            end else begin
                compare(it.val, it.tag);
            end
        end
    end

    // Driver side of the scoreboard: queue an expectation off cycles from now.
    task automatic expect_at(input int off, input logic [N-1:0] val, input string tag);
        exp_t it;
        int pos;
        it.at = cyc + off; it.val = val; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > it.at) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    // Drive one-edge strobes; on return cyc equals the edge that sampled them.
    task automatic step(input logic [N-1:0] a, input logic [N-1:0] l);
        arrive = a; leave = l;
        @(negedge clk);
        arrive = '0; leave = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: release=%b expected completion", release_o);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: reset state
        expect_at(1, '0, "R1 reset release low");
        idle(2);

        // R3 / R9: staggered arrivals with a duplicate strobe never release early
        step(4'b0001, '0);
        step(4'b0001, '0);
        step(4'b0010, '0);
        step(4'b0100, '0);
        idle(3);
        compare('0, "R3 R9 three counted, duplicate ignored");
        // R4: last arrival releases one edge later
        step(4'b1000, '0);
        compare('0, "R4 before final count");
        expect_at(1, 4'b1111, "R4 all released");
        idle(3);

        // R5: leave drops only that release; R8: re-arrive during exit is held
        step('0, 4'b0001);
        compare(4'b1110, "R5 leaver drops");
        step(4'b0001, '0);
        idle(3);
        compare(4'b1110, "R5 others keep release");
        step('0, 4'b1110);
        compare('0, "R5 all dropped");
        idle(6);
        step(4'b1110, '0);
        compare('0, "R8 round not complete");
        expect_at(2, '0, "R8 third pending grant");
        expect_at(3, 4'b1111, "R8 held arrival counted");
        idle(5);

        // R7 / R2: all leave together, all re-arrive while exiting
        step('0, 4'b1111);
        compare('0, "R5 all leave");
        step(4'b1111, '0);
        expect_at(6, '0, "R7 entry waits for empty barrier");
        expect_at(7, 4'b1111, "R7 R2 reuse after drain");
        idle(9);

        // R6: leave from unreleased participants is ignored; R2 simultaneous timing
        step('0, 4'b1111);
        idle(6);
        step('0, 4'b0010);
        step(4'b1111, '0);
        step('0, 4'b0010);
        step('0, 4'b0100);
        step('0, 4'b0001);
        compare('0, "R2 one grant per cycle");
        expect_at(1, 4'b1111, "R6 R2 ignored leaves, release at E+N");
        expect_at(3, 4'b1111, "R5 release held without leave");
        idle(5);

        step('0, 4'b1111);
        compare('0, "R5 final leave");
        idle(6);
        wait (sb.size() == 0);
        idle(1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule